// File: doc/BRIEF.md
# Serial Command Register Port

This block lets a host reach a bank of per-channel command registers over four wires: an active-low chip select, a serial clock, a serial data input and a serial data output. It serves a three-channel line interface, where each channel has a read-only status byte and two control bytes. The control bytes drive transmitter controls, a line-rate select and loopback selects. All serial inputs are oversampled by the system clock and resynchronised, so the core logic runs in a single clock domain. The serial clock must therefore run well below the system clock. A serial clock half-period of at least six system clocks is assumed.

Each frame opens with a direction flag, followed by a 5-bit register address and an 8-bit data word. Channel n owns an 8-address window. Offset 0 holds the channel's status, offset 1 its transmit controls and offset 4 its line configuration. The line configuration is decoded into a rate code and a loopback code. A synchronous clear input returns every writable register to its default value.

Top module: `ser_cfg_port`

## Requirements
- R1: A frame is 14 rising SCLK edges while cs_ni is low. The bits are: direction (1 = read, 0 = write), then address bits 0..4, then data bits 0..7, each sampled on a rising edge. A write takes effect only after the 14th rising edge.
- R2: Channel n uses addresses 8n to 8n+7. Offset 1 holds 5 transmit bits, presented on tx_ctrl_o[5n+4:5n]: bit0 binary mode, bit1 level, bit2 clock invert, bit3 all-ones, bit4 transmitter off. Offset 4 holds 4 line bits: bit0 remote loopback, bit1 local loopback, bit2 E3 select, bit3 STS-1 select. Both read back in the low bits, with zeros above.
- R3: Offset 0 of channel n reads {3'b0, status_i[5n+4:5n]}. The status bits are: bit0 drive monitor, bit1 digital LOS, bit2 analog LOS, bit3 receive LOS, bit4 loss of lock. Writes to offset 0 are ignored.
- R4: Offsets 2, 3, 5, 6 and 7, and addresses 24 to 31, read as zero, and writes to them change nothing.
- R5: In a read, SDO changes only after falling SCLK edges. Data bit k is valid at the rising edge that ends the (7+k)th bit period, LSB first.
- R6: sdo_oe_o is high exactly while cs_ni is low.
- R7: If cs_ni rises before the 14th rising edge, the frame is dropped with no write, and the next frame decodes from its first bit.
- R8: reg_clr_i high for one clock returns all writable registers to zero.
- R9: rate_o per channel is 2 (E3) when E3 select is set, else 1 (STS-1) when STS-1 select is set, else 0 (DS3). It never shows 3.
- R10: lb_mode_o per channel is 3 (digital local) when both loopback bits are set, 1 (analog local) for local only, 2 (remote) for remote only, and 0 otherwise.
- R11: After rst_ni, all writable registers are zero, rate_o is DS3 and lb_mode_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_clr_i | input | 1 | Synchronous clear of writable registers |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o (high drives the pin, low floats it) |
| status_i | input | NCH*5 | Per-channel status bits |
| tx_ctrl_o | output | NCH*5 | Per-channel transmit control bits |
| rate_o | output | NCH*2 | Per-channel decoded line rate |
| lb_mode_o | output | NCH*2 | Per-channel decoded loopback mode |

## Verification
The bench raises chip select after 10 and after 13 data-bearing edges. A design that committed early or kept a stale bit count would corrupt a control register or misread the next frame. It writes all-ones to the status offset, the gap offsets and the unused top window. A decoder that ignored the channel field or the read-only flag would then show the byte on tx_ctrl_o or in readback. It drives every combination of the rate and loopback bits, which catches a wrong E3 priority or a swapped loopback encoding. It also reads every byte back through SDO, so a shift that is off by one edge shows up as a halved or doubled value.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
  localparam int ADDR_W    = 5;
  localparam int OFF_W     = 3;
  localparam int DATA_W    = 8;
  localparam int STAT_W    = 5;
  localparam int TXC_W     = 5;
  localparam int LNC_W     = 4;
  localparam int FRAME_LEN = 1 + ADDR_W + DATA_W;

  localparam logic [OFF_W-1:0] OFF_STAT = 3'd0;
  localparam logic [OFF_W-1:0] OFF_TX   = 3'd1;
  localparam logic [OFF_W-1:0] OFF_LINE = 3'd4;

  typedef enum logic [1:0] {RATE_DS3 = 2'd0, RATE_STS1 = 2'd1, RATE_E3 = 2'd2} rate_e;
  typedef enum logic [1:0] {LB_NONE = 2'd0, LB_ANALOG = 2'd1, LB_REMOTE = 2'd2, LB_DIGITAL = 2'd3} lb_e;
endpackage

// File: rtl/ser_cfg_sync.sv
module ser_cfg_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ser_cfg_frame.sv
module ser_cfg_frame
  import ser_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              sclk_s_i,
  input  logic              sdi_s_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_stb_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              sclk_rise_o
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] C_ADDR = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] C_RD0  = CNT_W'(ADDR_W + 1);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] C_END  = CNT_W'(FRAME_LEN);

  logic [CNT_W-1:0]  cnt_q;
  logic              rw_q, sclk_d_q, sdo_q, stb_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q, sh_q;
  logic              rise, fall;

  assign rise = sclk_s_i & ~sclk_d_q;
  assign fall = ~sclk_s_i & sclk_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      rw_q     <= 1'b0;
      sclk_d_q <= 1'b0;
      sdo_q    <= 1'b0;
      stb_q    <= 1'b0;
      addr_q   <= '0;
      wd_q     <= '0;
      sh_q     <= '0;
    end else begin
      sclk_d_q <= sclk_s_i;
      stb_q    <= 1'b0;
      if (cs_n_s_i) begin
        cnt_q <= '0;
        rw_q  <= 1'b0;
        sdo_q <= 1'b0;
      end else begin
        if (rise) begin
          if (cnt_q == '0)          rw_q   <= sdi_s_i;
          else if (cnt_q <= C_ADDR) addr_q <= {sdi_s_i, addr_q[ADDR_W-1:1]};
          else if (cnt_q < C_END)   wd_q   <= {sdi_s_i, wd_q[DATA_W-1:1]};
          // commit only on the last bit of a complete write frame
          if (cnt_q == C_LAST && !rw_q) stb_q <= 1'b1;
          if (cnt_q < C_END) cnt_q <= cnt_q + 1'b1;
        end
        if (fall && rw_q) begin
          if (cnt_q == C_RD0) begin
            sdo_q <= rd_data_i[0];
            sh_q  <= {1'b0, rd_data_i[DATA_W-1:1]};
          end else if (cnt_q > C_RD0 && cnt_q < C_END) begin
            sdo_q <= sh_q[0];
            sh_q  <= {1'b0, sh_q[DATA_W-1:1]};
          end else begin
            sdo_q <= 1'b0;
          end
        end
      end
    end
  end

  assign addr_o      = addr_q;
  assign wr_stb_o    = stb_q;
  assign wr_data_o   = wd_q;
  assign sdo_o       = sdo_q;
  assign sclk_rise_o = rise;
endmodule

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank
  import ser_cfg_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NCH*STAT_W-1:0] status_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NCH*TXC_W-1:0] tx_ctrl_o,
  output logic [NCH*2-1:0]  rate_o,
  output logic [NCH*2-1:0]  lb_mode_o
);
  localparam int CH_W = ADDR_W - OFF_W;

  logic [CH_W-1:0]  chan;
  logic [OFF_W-1:0] off;
  logic [NCH-1:0][DATA_W-1:0] rd_ch;

  assign chan = addr_i[ADDR_W-1:OFF_W];
  assign off  = addr_i[OFF_W-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [TXC_W-1:0] tx_q;
    logic [LNC_W-1:0] ln_q;
    logic             sel;
    rate_e            rate;
    lb_e              lb;

    assign sel = (chan == CH_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tx_q <= '0;
        ln_q <= '0;
      end else if (clr_i) begin
        tx_q <= '0;
        ln_q <= '0;
      end else if (wr_stb_i && sel) begin
        if (off == OFF_TX)   tx_q <= wr_data_i[TXC_W-1:0];
        if (off == OFF_LINE) ln_q <= wr_data_i[LNC_W-1:0];
      end
    end

    always_comb begin
      case (off)
        OFF_STAT: rd_ch[g] = DATA_W'(status_i[g*STAT_W +: STAT_W]);
        OFF_TX:   rd_ch[g] = DATA_W'(tx_q);
        OFF_LINE: rd_ch[g] = DATA_W'(ln_q);
        default:  rd_ch[g] = '0;
      endcase
    end

    // E3 select overrides STS-1 select
    always_comb begin
      if (ln_q[2])      rate = RATE_E3;
      else if (ln_q[3]) rate = RATE_STS1;
      else              rate = RATE_DS3;
    end

    always_comb begin
      unique case (ln_q[1:0])
        2'b11:   lb = LB_DIGITAL;
        2'b10:   lb = LB_ANALOG;
        2'b01:   lb = LB_REMOTE;
        default: lb = LB_NONE;
      endcase
    end

    assign tx_ctrl_o[g*TXC_W +: TXC_W] = tx_q;
    assign rate_o[g*2 +: 2]            = rate;
    assign lb_mode_o[g*2 +: 2]         = lb;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (chan == CH_W'(i)) rd_data_o = rd_ch[i];
    end
  end
endmodule

// File: rtl/ser_cfg_port.sv
module ser_cfg_port
  import ser_cfg_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_clr_i,
  input  logic                  cs_ni,
  input  logic                  sclk_i,
  input  logic                  sdi_i,
  output logic                  sdo_o,
  output logic                  sdo_oe_o,
  input  logic [NCH*STAT_W-1:0] status_i,
  output logic [NCH*TXC_W-1:0]  tx_ctrl_o,
  output logic [NCH*2-1:0]      rate_o,
  output logic [NCH*2-1:0]      lb_mode_o
);
  logic [2:0]        pins_s;
  logic              wr_stb, sclk_rise;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  ser_cfg_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sclk_i, sdi_i}),
    .q_o    (pins_s)
  );

  ser_cfg_frame u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_n_s_i    (pins_s[2]),
    .sclk_s_i    (pins_s[1]),
    .sdi_s_i     (pins_s[0]),
    .rd_data_i   (rd_data),
    .addr_o      (wr_addr),
    .wr_stb_o    (wr_stb),
    .wr_data_o   (wr_data),
    .sdo_o       (sdo_o),
    .sclk_rise_o (sclk_rise)
  );

  ser_cfg_bank #(.NCH(NCH)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (reg_clr_i),
    .wr_stb_i  (wr_stb),
    .addr_i    (wr_addr),
    .wr_data_i (wr_data),
    .status_i  (status_i),
    .rd_data_o (rd_data),
    .tx_ctrl_o (tx_ctrl_o),
    .rate_o    (rate_o),
    .lb_mode_o (lb_mode_o)
  );

  // the pin floats as soon as the host releases select
  assign sdo_oe_o = ~cs_ni;
endmodule

// File: rtl/ser_cfg_port_chk.sv
module ser_cfg_port_chk
  import ser_cfg_pkg::*;
#(
  parameter int NCH = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_clr_i,
  input logic                 wr_stb,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic                 sclk_rise,
  input logic                 sdo_o,
  input logic [NCH*TXC_W-1:0] tx_ctrl_o,
  input logic [NCH*2-1:0]     rate_o,
  input logic [NCH*2-1:0]     lb_mode_o
);
  // R8
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_clr_i |=> (tx_ctrl_o == '0) && (rate_o == '0) && (lb_mode_o == '0));

  // R7
  tx_change_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_ctrl_o) |-> ($past(wr_stb) || $past(reg_clr_i)));

  // R4
  unused_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && !reg_clr_i && wr_addr >= ADDR_W'(NCH * 8)) |=>
      ($stable(tx_ctrl_o) && $stable(rate_o) && $stable(lb_mode_o)));

  // R5
  sdo_rise_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise |=> $stable(sdo_o));

  for (genvar g = 0; g < NCH; g++) begin : g_rate
    // R9
    rate_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rate_o[g*2 +: 2] != 2'b11);
  end
endmodule

bind ser_cfg_port ser_cfg_port_chk #(.NCH(NCH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_clr_i (reg_clr_i),
  .wr_stb    (wr_stb),
  .wr_addr   (wr_addr),
  .sclk_rise (sclk_rise),
  .sdo_o     (sdo_o),
  .tx_ctrl_o (tx_ctrl_o),
  .rate_o    (rate_o),
  .lb_mode_o (lb_mode_o)
);

// File: tb/ser_cfg_port_bench.sv
module ser_cfg_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NCH        = 3;

  logic clk = 1'b0;
  logic rst_ni, reg_clr_i, cs_ni, sclk_i, sdi_i;
  logic sdo_o, sdo_oe_o;
  logic [NCH*5-1:0] status_i;
  logic [NCH*5-1:0] tx_ctrl_o;
  logic [NCH*2-1:0] rate_o, lb_mode_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_cfg_port #(.NCH(NCH)) u_ser_cfg_port (
    .clk_i(clk), .rst_ni(rst_ni), .reg_clr_i(reg_clr_i),
    .cs_ni(cs_ni), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .status_i(status_i),
    .tx_ctrl_o(tx_ctrl_o), .rate_o(rate_o), .lb_mode_o(lb_mode_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pairs captured read bytes with expected ones
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {24'd0, a}, {24'd0, e});
      end
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input bit rw, input logic [4:0] a, input logic [7:0] d,
                       input int nbits, output logic [7:0] q);
    logic [13:0] bits;
    bits = {d, a, rw};
    q = '0;
    cs_ni = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sclk_i = 1'b0;
      sdi_i  = bits[i];
      wait_clk(HALF);
      if (rw && i >= 6) q[i-6] = sdo_o;
      sclk_i = 1'b1;
      wait_clk(HALF);
    end
    sclk_i = 1'b0;
    wait_clk(HALF);
    cs_ni = 1'b1;
    wait_clk(2*HALF);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] q;
    frame(1'b0, a, d, 14, q);
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic [7:0] e);
    logic [7:0] q;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    frame(1'b1, a, 8'h00, 14, q);
    act_q.push_back(q);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    rst_ni = 1'b0; reg_clr_i = 1'b0; cs_ni = 1'b1;
    sclk_i = 1'b0; sdi_i = 1'b0; status_i = '0;
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(3);

    // R11 reset state
    chk("R11 tx_ctrl reset", tx_ctrl_o, 0);
    chk("R11 rate reset", rate_o, 0);
    chk("R11 lb reset", lb_mode_o, 0);
    // R6 released select floats the output
    chk("R6 oe with cs high", sdo_oe_o, 0);
    rd("R11 ch0 tx readback after reset", 5'd1, 8'h00);

    // R6 enable follows select
    cs_ni = 1'b0; wait_clk(2);
    chk("R6 oe with cs low", sdo_oe_o, 1);
    cs_ni = 1'b1; wait_clk(2*HALF);

    // R1 R2 writes and readback, LSB-first framing
    wr(5'd1, 8'h15);
    chk("R1 ch0 tx_ctrl", tx_ctrl_o[4:0], 5'h15);
    rd("R5 ch0 tx readback", 5'd1, 8'h15);
    wr(5'd9, 8'hFF);
    chk("R2 ch1 tx_ctrl truncated", tx_ctrl_o[9:5], 5'h1F);
    chk("R2 ch0 untouched", tx_ctrl_o[4:0], 5'h15);
    rd("R2 ch1 tx readback", 5'd9, 8'h1F);
    wr(5'd17, 8'h06);
    chk("R2 ch2 tx_ctrl", tx_ctrl_o[14:10], 5'h06);

    // R9 rate decode on ch2 (offset 4 = addr 20)
    wr(5'd20, 8'h0C);
    chk("R9 E3 over STS1", rate_o[5:4], 2);
    wr(5'd20, 8'h08);
    chk("R9 STS1", rate_o[5:4], 1);
    wr(5'd20, 8'h04);
    chk("R9 E3 alone", rate_o[5:4], 2);
    wr(5'd20, 8'h00);
    chk("R9 DS3", rate_o[5:4], 0);

    // R10 loopback decode on ch1 (addr 12)
    wr(5'd12, 8'h03);
    chk("R10 digital", lb_mode_o[3:2], 3);
    wr(5'd12, 8'h02);
    chk("R10 analog", lb_mode_o[3:2], 1);
    wr(5'd12, 8'h01);
    chk("R10 remote", lb_mode_o[3:2], 2);
    rd("R2 ch1 line readback", 5'd12, 8'h01);

    // R3 status read-only
    status_i = {5'h00, 5'h16, 5'h09};
    rd("R3 ch1 status", 5'd8, 8'h16);
    wr(5'd8, 8'hFF);
    rd("R3 ch1 status after write", 5'd8, 8'h16);
    chk("R3 write to status leaves tx", tx_ctrl_o[9:5], 5'h1F);
    rd("R3 ch0 status", 5'd0, 8'h09);

    // R4 unused offsets and window
    wr(5'd2, 8'hFF);
    rd("R4 ch0 offset2", 5'd2, 8'h00);
    wr(5'd7, 8'hFF);
    rd("R4 ch0 offset7", 5'd7, 8'h00);
    wr(5'd25, 8'hFF);
    wr(5'd28, 8'hFF);
    rd("R4 addr25", 5'd25, 8'h00);
    rd("R4 addr28", 5'd28, 8'h00);
    chk("R4 tx_ctrl unchanged", tx_ctrl_o, {5'h06, 5'h1F, 5'h15});
    chk("R4 lb unchanged", lb_mode_o, {2'd0, 2'd2, 2'd0});

    // R7 aborted write frames
    frame(1'b0, 5'd1, 8'h0A, 10, q);
    chk("R7 abort after 10", tx_ctrl_o[4:0], 5'h15);
    frame(1'b0, 5'd1, 8'h0A, 13, q);
    chk("R7 abort after 13", tx_ctrl_o[4:0], 5'h15);
    frame(1'b1, 5'd9, 8'h00, 9, q);
    rd("R7 read after aborted read", 5'd1, 8'h15);
    wr(5'd1, 8'h0A);
    chk("R7 write after aborts", tx_ctrl_o[4:0], 5'h0A);

    // R8 register clear
    reg_clr_i = 1'b1; wait_clk(1); reg_clr_i = 1'b0; wait_clk(2);
    chk("R8 tx cleared", tx_ctrl_o, 0);
    chk("R8 lb cleared", lb_mode_o, 0);
    chk("R8 rate cleared", rate_o, 0);
    rd("R8 ch1 line readback", 5'd12, 8'h00);
    rd("R8 status survives clear", 5'd8, 8'h16);

    wait_clk(20);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule